// File: doc/BRIEF.md
# Direction-Aware FIFO Service Interrupt

This block is a byte FIFO between a host bus and a parallel-port data path. The transfer direction is held in a register. In forward mode the host writes bytes and the port side drains them. In reverse mode the port side fills the FIFO and the host reads it. The FIFO raises a service interrupt when enough room or enough data is present for the host to move a whole burst without polling status.

The interrupt threshold follows the direction. In forward mode it fires when occupancy is low enough that at least 12 bytes are free. In reverse mode it fires when at least 12 bytes are waiting. A service bit gates the interrupt. Hardware sets the bit in the same cycle the interrupt fires, so the interrupt masks itself. Software writes the bit back to 0 to re-arm it. Full and empty flags let the host choose between a 12-byte burst and a whole-FIFO burst. Writing a new direction flushes the FIFO.

Top module: `svc_fifo_irq`

## Requirements
- R1: After reset, level is 0, empty is 1, full is 0, svc_bit is 1 (masked), irq is 0 and dir_cur is 0 (forward).
- R2: Bytes leave the FIFO in the order they entered. The oldest stored byte is presented on host_rdata and on port_rdata before it is popped.
- R3: With dir_cur=0 (forward), host_wr pushes and port_pop pops. With dir_cur=1 (reverse), port_push pushes and host_rd pops. Strobes of the side that is inactive for the current direction change nothing.
- R4: In forward mode, if svc_bit is 0 and level is 4 or less (16 minus 12) at a clock edge, irq is 1 after the next edge. While level is 5 or more, no forward interrupt is raised.
- R5: In reverse mode, if svc_bit is 0 and level is 12 or more at a clock edge, irq is 1 after the next edge. While level is 11 or less, no reverse interrupt is raised.
- R6: The edge that raises irq also sets svc_bit to 1. irq stays high for exactly one cycle. irq never rises while svc_bit is 1.
- R7: A write with svc_wr=1 and svc_wdata=0 clears svc_bit at that edge. If the threshold condition still holds, irq rises one edge later.
- R8: A push while full and a pop while empty are ignored. level never exceeds 16 and never wraps below 0.
- R9: A push and a pop in the same cycle, with the FIFO neither full nor empty, leave level unchanged and keep the byte order.
- R10: A write with dir_wr=1 and a dir_wdata that differs from dir_cur switches the direction and empties the FIFO at that edge. Writing the current direction again leaves the contents intact.
- R11: full is 1 exactly when level is 16, and empty is 1 exactly when level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_wr | input | 1 | Direction register write strobe |
| dir_wdata | input | 1 | New direction: 0 forward (host to port), 1 reverse (port to host) |
| dir_cur | output | 1 | Current direction |
| svc_wr | input | 1 | Service bit write strobe |
| svc_wdata | input | 1 | Value written to the service bit |
| svc_bit | output | 1 | Service bit: 1 masks the interrupt |
| host_wr | input | 1 | Host push strobe (forward mode) |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host pop strobe (reverse mode) |
| host_rdata | output | 8 | Oldest byte, as seen by the host |
| port_push | input | 1 | Port-side push strobe (reverse mode) |
| port_wdata | input | 8 | Port-side write byte |
| port_pop | input | 1 | Port-side pop strobe (forward mode) |
| port_rdata | output | 8 | Oldest byte, as seen by the port side |
| level | output | 5 | Number of stored bytes, 0 to 16 |
| full | output | 1 | FIFO holds 16 bytes |
| empty | output | 1 | FIFO holds no bytes |
| irq | output | 1 | Registered one-cycle service interrupt |

## Verification
A wrong occupancy count shows up at the ports in the cycle after the faulty push or pop, through level and the flags. It shows up one cycle later through irq, when the interrupt fires one byte early or late at the 4 and 12 boundaries. A pointer that is out of step with the count appears as a wrong byte on the read data at the very next pop, so the bench compares every popped byte with its own record. A service bit that fails to set, or fails to re-arm, appears as a second irq pulse or a missing one within two cycles of the firing or re-arming edge.

// File: rtl/svc_fifo_pkg.sv
// Shared definitions for the direction-aware service FIFO.
// Assumes: a single clock domain; the direction is one bit.
package svc_fifo_pkg;
    typedef enum logic {
        XFER_FWD = 1'b0,  // host writes, port side reads
        XFER_REV = 1'b1   // port side writes, host reads
    } xfer_dir_e;
endpackage

// File: rtl/sfq_store.sv
// Circular byte storage with read and write pointers.
// Assumes: push and pop arrive already qualified against full and empty.
// The head entry is visible combinationally (first-word fall-through).
module sfq_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Pointer update with explicit wrap, so DEPTH need not be a power of two.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Data array write; no reset needed on the contents.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= wdata;
    end

    // Head of queue.
    assign rdata = mem[rd_ptr];
endmodule

// File: rtl/sfq_occ.sv
// Occupancy counter with registered full and empty flags.
// Assumes: a flush wins over a push or pop in the same cycle.
// Blocks a push while full and a pop while empty.
module sfq_occ #(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push_req,
    input  logic                         pop_req,
    output logic                         push_ok,
    output logic                         pop_ok,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] TOP = LW'(DEPTH);

    logic [LW-1:0] nxt;

    // Qualify the requests against the current flags.
    assign push_ok = push_req && !full && !flush;
    assign pop_ok  = pop_req && !empty && !flush;

    // Next occupancy from the qualified strobes.
    always_comb begin
        nxt = level;
        if (push_ok && !pop_ok) nxt = level + 1'b1;
        if (pop_ok && !push_ok) nxt = level - 1'b1;
    end

    // Register the count and the flags together.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            level <= '0;
            full  <= 1'b0;
            empty <= 1'b1;
        end else begin
            level <= nxt;
            full  <= (nxt == TOP);
            empty <= (nxt == '0);
        end
    end
endmodule

// File: rtl/sfq_svc_irq.sv
// Service-bit and interrupt generator.
// The threshold test depends on the direction: low occupancy in forward,
// high occupancy in reverse. Firing sets the service bit, which masks
// further firing until software writes it back to 0.
// Assumes: level is the registered occupancy; irq is a registered pulse.
module sfq_svc_irq #(
    parameter int LW     = 5,
    parameter int DEPTH  = 16,
    parameter int THRESH = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  svc_fifo_pkg::xfer_dir_e  dir,
    input  logic [LW-1:0]            level,
    input  logic                     svc_wr,
    input  logic                     svc_wdata,
    output logic                     svc,
    output logic                     irq
);
    import svc_fifo_pkg::*;

    localparam logic [LW-1:0] REV_AT = LW'(THRESH);
    localparam logic [LW-1:0] FWD_AT = LW'(DEPTH - THRESH);

    logic hit;
    logic fire;

    // Direction-selected threshold test.
    always_comb begin
        if (dir == XFER_REV) hit = (level >= REV_AT);
        else                 hit = (level <= FWD_AT);
    end

    assign fire = hit && !svc;

    // Service bit: software write, then hardware set on firing.
    always_ff @(posedge clk) begin
        if (!rst_n)          svc <= 1'b1;
        else if (fire)       svc <= 1'b1;
        else if (svc_wr)     svc <= svc_wdata;
    end

    // Registered interrupt output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= fire;
    end
endmodule

// File: rtl/svc_fifo_irq.sv
// Top level: direction register, side selection and the three sub-blocks.
// Assumes: the inactive side's strobes are don't-care; a direction change
// flushes the FIFO and takes priority over any push or pop in that cycle.
module svc_fifo_irq #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    parameter int THRESH = 12,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_wr,
    input  logic             dir_wdata,
    output logic             dir_cur,
    input  logic             svc_wr,
    input  logic             svc_wdata,
    output logic             svc_bit,
    input  logic             host_wr,
    input  logic [WIDTH-1:0] host_wdata,
    input  logic             host_rd,
    output logic [WIDTH-1:0] host_rdata,
    input  logic             port_push,
    input  logic [WIDTH-1:0] port_wdata,
    input  logic             port_pop,
    output logic [WIDTH-1:0] port_rdata,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             irq
);
    import svc_fifo_pkg::*;

    xfer_dir_e        dir_q;
    logic             flush;
    logic             push_req;
    logic             pop_req;
    logic             push_ok;
    logic             pop_ok;
    logic [WIDTH-1:0] in_byte;
    logic [WIDTH-1:0] head;

    // Direction register; a changed value requests a flush.
    always_ff @(posedge clk) begin
        if (!rst_n)      dir_q <= XFER_FWD;
        else if (dir_wr) dir_q <= xfer_dir_e'(dir_wdata);
    end

    assign flush = dir_wr && (dir_wdata != dir_q);

    // Route the active side's strobes and data to the queue.
    always_comb begin
        if (dir_q == XFER_REV) begin
            push_req = port_push;
            pop_req  = host_rd;
            in_byte  = port_wdata;
        end else begin
            push_req = host_wr;
            pop_req  = port_pop;
            in_byte  = host_wdata;
        end
    end

    sfq_occ #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_req (push_req),
        .pop_req  (pop_req),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .level    (level),
        .full     (full),
        .empty    (empty)
    );

    sfq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (push_ok),
        .pop   (pop_ok),
        .wdata (in_byte),
        .rdata (head)
    );

    sfq_svc_irq #(.LW(LW), .DEPTH(DEPTH), .THRESH(THRESH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir       (dir_q),
        .level     (level),
        .svc_wr    (svc_wr),
        .svc_wdata (svc_wdata),
        .svc       (svc_bit),
        .irq       (irq)
    );

    assign dir_cur    = dir_q;
    assign host_rdata = head;
    assign port_rdata = head;
endmodule

// File: rtl/svc_fifo_irq_chk.sv
// Property checker for svc_fifo_irq, bound to every instance of the top.
// Assumes: the same parameters as the top; observes ports only.
module svc_fifo_irq_chk #(
    parameter int DEPTH  = 16,
    parameter int THRESH = 12,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dir_wr,
    input logic          dir_wdata,
    input logic          dir_cur,
    input logic          svc_bit,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          empty,
    input logic          irq
);
    localparam logic [LW-1:0] TOP    = LW'(DEPTH);
    localparam logic [LW-1:0] REV_AT = LW'(THRESH);
    localparam logic [LW-1:0] FWD_AT = LW'(DEPTH - THRESH);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= TOP); // R8

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R11

    AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == TOP)); // R11

    AST_FWD_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_bit && !dir_cur && level <= FWD_AT) |=> irq); // R4

    AST_REV_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (!svc_bit && dir_cur && level >= REV_AT) |=> irq); // R5

    AST_IRQ_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> svc_bit); // R6

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R6

    AST_NO_FIRE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        svc_bit |=> !irq); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr && (dir_wdata != dir_cur)) |=> empty); // R10
endmodule

bind svc_fifo_irq svc_fifo_irq_chk #(.DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_wr    (dir_wr),
    .dir_wdata (dir_wdata),
    .dir_cur   (dir_cur),
    .svc_bit   (svc_bit),
    .level     (level),
    .full      (full),
    .empty     (empty),
    .irq       (irq)
);

// File: tb/tb_svc_fifo_irq.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_svc_fifo_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_wr = 1'b0, dir_wdata = 1'b0, dir_cur;
    logic       svc_wr = 1'b0, svc_wdata = 1'b0, svc_bit;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00, host_rdata;
    logic       port_push = 1'b0, port_pop = 1'b0;
    logic [7:0] port_wdata = 8'h00, port_rdata;
    logic [4:0] level;
    logic       full, empty, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    svc_fifo_irq dut (
        .clk(clk), .rst_n(rst_n),
        .dir_wr(dir_wr), .dir_wdata(dir_wdata), .dir_cur(dir_cur),
        .svc_wr(svc_wr), .svc_wdata(svc_wdata), .svc_bit(svc_bit),
        .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata),
        .port_push(port_push), .port_wdata(port_wdata),
        .port_pop(port_pop), .port_rdata(port_rdata),
        .level(level), .full(full), .empty(empty), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_svc(logic v);
        svc_wr = 1'b1; svc_wdata = v; tick(); svc_wr = 1'b0;
    endtask

    task automatic set_dir(logic v);
        dir_wr = 1'b1; dir_wdata = v; tick(); dir_wr = 1'b0;
    endtask

    task automatic host_push(logic [7:0] b);
        host_wr = 1'b1; host_wdata = b; tick(); host_wr = 1'b0;
    endtask

    task automatic side_push(logic [7:0] b);
        port_push = 1'b1; port_wdata = b; tick(); port_push = 1'b0;
    endtask

    task automatic side_pop_expect(logic [7:0] b, string req);
        check(req, "port_rdata", port_rdata, b);
        port_pop = 1'b1; tick(); port_pop = 1'b0;
    endtask

    task automatic host_pop_expect(logic [7:0] b, string req);
        check(req, "host_rdata", host_rdata, b);
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "level", level, 0);
        check("R1", "empty", empty, 1);
        check("R1", "full", full, 0);
        check("R1", "svc_bit", svc_bit, 1);
        check("R1", "irq", irq, 0);
        check("R1", "dir_cur", dir_cur, 0);
    endtask

    task automatic t_forward();
        set_svc(1'b0);                 // armed; level 0 meets forward test
        check("R6", "irq before fire edge", irq, 0);
        tick();
        check("R4", "irq at level 0", irq, 1);
        check("R6", "svc set by fire", svc_bit, 1);
        tick();
        check("R6", "irq one cycle", irq, 0);
        for (int i = 0; i < 16; i++) host_push(8'(8'h40 + i));
        check("R11", "full at 16", full, 1);
        check("R11", "level 16", level, 16);
        host_push(8'hEE);
        check("R8", "push while full", level, 16);
        port_push = 1'b1; port_wdata = 8'h77; host_rd = 1'b1; tick();
        port_push = 1'b0; host_rd = 1'b0;
        check("R3", "inactive side in forward", level, 16);
        set_svc(1'b0);
        tick(); tick();
        check("R4", "no irq at level 16", irq, 0);
        for (int i = 0; i < 11; i++) side_pop_expect(8'(8'h40 + i), "R2");
        check("R4", "level 5", level, 5);
        tick();
        check("R4", "no irq at level 5", irq, 0);
        side_pop_expect(8'h4B, "R2");
        check("R4", "level 4", level, 4);
        tick();
        check("R4", "irq at level 4", irq, 1);
        for (int i = 12; i < 16; i++) side_pop_expect(8'(8'h40 + i), "R2");
        check("R11", "empty at 0", empty, 1);
        port_pop = 1'b1; tick(); port_pop = 1'b0;
        check("R8", "pop while empty", level, 0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 3; i++) host_push(8'(i));
        check("R10", "level before switch", level, 3);
        set_dir(1'b1);
        check("R10", "dir_cur after switch", dir_cur, 1);
        check("R10", "level after switch", level, 0);
        check("R10", "empty after switch", empty, 1);
        side_push(8'h51); side_push(8'h52);
        set_dir(1'b1);
        check("R10", "same dir keeps level", level, 2);
        host_pop_expect(8'h51, "R10");
        set_dir(1'b0);
        set_dir(1'b1);
        check("R10", "empty after double switch", level, 0);
    endtask

    task automatic t_reverse();
        set_svc(1'b0);
        tick();
        check("R5", "no irq at level 0", irq, 0);
        for (int i = 0; i < 11; i++) side_push(8'(8'hA0 + i));
        tick();
        check("R5", "no irq at level 11", irq, 0);
        side_push(8'hAB);
        check("R5", "level 12", level, 12);
        tick();
        check("R5", "irq at level 12", irq, 1);
        check("R6", "svc set by fire", svc_bit, 1);
        for (int i = 12; i < 16; i++) side_push(8'(8'hA0 + i));
        check("R6", "no irq while masked", irq, 0);
        host_push(8'h99);
        port_pop = 1'b1; tick(); port_pop = 1'b0;
        check("R3", "inactive side in reverse", level, 16);
        set_svc(1'b0);
        check("R7", "svc cleared", svc_bit, 0);
        check("R7", "irq not yet", irq, 0);
        tick();
        check("R7", "irq after re-arm", irq, 1);
        for (int i = 0; i < 16; i++) host_pop_expect(8'(8'hA0 + i), "R2");
        check("R11", "empty after burst", empty, 1);
    endtask

    task automatic t_simul();
        side_push(8'h10); side_push(8'h11); side_push(8'h12);
        check("R9", "host_rdata head", host_rdata, 8'h10);
        port_push = 1'b1; port_wdata = 8'h13; host_rd = 1'b1; tick();
        port_push = 1'b0; host_rd = 1'b0;
        check("R9", "level unchanged", level, 3);
        host_pop_expect(8'h11, "R9");
        host_pop_expect(8'h12, "R9");
        host_pop_expect(8'h13, "R9");
        check("R9", "level drained", level, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_forward();
        t_flush();
        t_reverse();
        t_simul();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule